// File: doc/BRIEF.md
# Log-Step Parallel Prefix Scan Unit

This block takes a vector of N words, with N a power of two, and produces their inclusive prefix under an associative operator picked at start time. Output word k is the left-to-right combination of input words 0 through k, so word 0 is a copy of input word 0. The operator does not need to be commutative. In every combine, the word with the lower index is the left operand.

Inputs and the operator code are captured on a start pulse while the unit is idle. The unit then runs lg N rounds, one per clock cycle. In round j, each word whose index is at least 2^j is combined with the word 2^j places below it. Words below that index keep their value. Each round reads only the register values left by the previous round. After the last round, a one-cycle done pulse marks the result vector, and that vector stays on the output until the next accepted start.

Top module: `prefix_scan_unit`

## Requirements
- R1: While reset is high and after its release, busy and done are 0 and every output word is 0.
- R2: A start seen while idle (busy low) captures data_in and op_sel and raises busy for exactly lg N cycles. Done is high for one cycle only, in the lg N-th cycle after the capturing edge, and busy is low in that cycle.
- R3: When done is high, output word k (bits k*W and up) equals in0 ⊕ in1 ⊕ … ⊕ ink, folded left to right. Word 0 equals in0 and never changes while the unit is busy.
- R4: op_sel codes 0 to 2: 0 is addition modulo 2^W, 1 is multiplication keeping the low W bits, 2 is unsigned maximum.
- R5: op_sel codes 3 to 6: 3 is unsigned minimum, 4 is bitwise AND, 5 is bitwise OR, 6 is bitwise XOR.
- R6: op_sel code 7 is affine composition, which is not commutative. Each word is split into a high half a and a low half b, each W/2 bits. A lower-indexed left operand (a1,b1) and a right operand (a2,b2) give high half a1*a2 and low half a2*b1+b2, both modulo 2^(W/2).
- R7: While busy, a start pulse and any change on data_in or op_sel have no effect. Done timing and the result are those of the scan already running.
- R8: While idle with start low, the output vector holds its value, whatever data_in and op_sel do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture inputs and begin a scan when idle |
| op_sel | input | 3 | Operator code, sampled with start |
| data_in | input | N*W | Input words, word i in bits i*W up to i*W+W-1 |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse marking a finished result |
| data_out | output | N*W | Working and result vector, same word layout |

## Verification
The bound assertions check the cycle-level control on every cycle. They cover the one-cycle done pulse that arrives only after exactly lg N busy cycles, the absence of overlap between busy and done, the fixed lowest word during the rounds, and the hold of the output while idle. The values themselves can only be shown by the directed scenarios. These compare every word against a sequential left-to-right fold for all eight operator codes, including wrap-around corners. The affine composition case exposes any swapped operand order. The scenarios also push a second start, a new operator and new data into a running scan and confirm that the first result comes out unchanged.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_MUL    = 3'd1,
    OP_MAX    = 3'd2,
    OP_MIN    = 3'd3,
    OP_AND    = 3'd4,
    OP_OR     = 3'd5,
    OP_XOR    = 3'd6,
    OP_AFFINE = 3'd7
  } scan_op_e;
endpackage

// File: rtl/scan_combine.sv
// One operator cell: res = lhs (lower index) combined with rhs (higher index).
module scan_combine
  import scan_pkg::*;
#(
  parameter int W = 16  // must be even for the affine code
) (
  input  scan_op_e       op,
  input  logic [W-1:0]   lhs,
  input  logic [W-1:0]   rhs,
  output logic [W-1:0]   res
);
  localparam int H = W / 2;

  logic [H-1:0] l_mul, l_add, r_mul, r_add;
  logic [H-1:0] aff_hi, aff_lo;

  assign l_mul = lhs[W-1:H];
  assign l_add = lhs[H-1:0];
  assign r_mul = rhs[W-1:H];
  assign r_add = rhs[H-1:0];

  always_comb begin
    aff_hi = l_mul * r_mul;
    aff_lo = r_mul * l_add + r_add;
    case (op)
      OP_ADD:    res = lhs + rhs;
      OP_MUL:    res = lhs * rhs;
      OP_MAX:    res = (lhs > rhs) ? lhs : rhs;
      OP_MIN:    res = (lhs < rhs) ? lhs : rhs;
      OP_AND:    res = lhs & rhs;
      OP_OR:     res = lhs | rhs;
      OP_XOR:    res = lhs ^ rhs;
      OP_AFFINE: res = {aff_hi, aff_lo};
      default:   res = lhs + rhs;
    endcase
  end
endmodule

// File: rtl/scan_sequencer.sv
// Round counter: accepts a start only when idle, runs LG rounds, pulses done.
module scan_sequencer #(
  parameter int LG = 3,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] round
);
  localparam logic [CW-1:0] LAST = CW'(LG - 1);

  assign load = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      round <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        round <= '0;
      end else if (busy) begin
        if (round == LAST) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          round <= '0;
        end else begin
          round <= round + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prefix_scan_unit.sv
module prefix_scan_unit
  import scan_pkg::*;
#(
  parameter int N = 8,   // power of two, at least 2
  parameter int W = 16   // even
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     op_sel,
  input  logic [N*W-1:0] data_in,
  output logic           busy,
  output logic           done,
  output logic [N*W-1:0] data_out
);
  localparam int LG = $clog2(N);
  localparam int CW = (LG > 1) ? $clog2(LG) : 1;
  localparam int NR = 2 ** CW;

  logic [N-1:0][W-1:0] lanes, lanes_in, left, sum;
  logic [N-1:0]        act;
  logic [CW-1:0]       round;
  logic                load;
  scan_op_e            op_q;

  assign lanes_in = data_in;
  assign data_out = lanes;

  scan_sequencer #(.LG(LG), .CW(CW)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .busy  (busy),
    .done  (done),
    .round (round)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [NR-1:0][W-1:0] cand;
    logic [NR-1:0]        ok;
    for (genvar r = 0; r < NR; r++) begin : g_dist
      if (r < LG && i >= (1 << r)) begin : g_on
        assign cand[r] = lanes[i - (1 << r)];
        assign ok[r]   = 1'b1;
      end else begin : g_off
        assign cand[r] = '0;
        assign ok[r]   = 1'b0;
      end
    end
    assign left[i] = cand[round];
    assign act[i]  = ok[round];

    scan_combine #(.W(W)) u_cmb (
      .op  (op_q),
      .lhs (left[i]),
      .rhs (lanes[i]),
      .res (sum[i])
    );
  end

  // All lanes update from the same pre-edge snapshot (nonblocking).
  always_ff @(posedge clk) begin
    if (rst) begin
      lanes <= '0;
      op_q  <= OP_ADD;
    end else if (load) begin
      lanes <= lanes_in;
      op_q  <= scan_op_e'(op_sel);
    end else if (busy) begin
      for (int i = 0; i < N; i++) begin
        if (act[i]) lanes[i] <= sum[i];
      end
    end
  end
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [N*W-1:0] data_out
);
  localparam int LG = $clog2(N);
  localparam int BW = $clog2(LG + 1) + 1;

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_done_after_rounds: assert property (@(posedge clk) disable iff (rst)
    done |-> bcnt == BW'(LG));

  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_no_overrun: assert property (@(posedge clk) disable iff (rst)
    busy |-> bcnt < BW'(LG));

  a_r3_lane0_fixed: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(data_out[W-1:0]));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(data_out));
endmodule

bind prefix_scan_unit scan_checker #(.N(N), .W(W)) u_scan_checker (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .data_out (data_out)
);

// File: tb/test_prefix_scan_unit.sv
`timescale 1ns/1ps
module test_prefix_scan_unit;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int LG = 3;
  localparam int H  = W / 2;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [2:0]     op_sel;
  logic [N*W-1:0] data_in;
  logic           busy, done;
  logic [N*W-1:0] data_out;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [N*W-1:0] last_exp;

  prefix_scan_unit #(.N(N), .W(W)) i_prefix_scan_unit (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
    .data_in(data_in), .busy(busy), .done(done), .data_out(data_out)
  );

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] ref_op(input logic [2:0] op,
                                          input logic [W-1:0] l,
                                          input logic [W-1:0] r);
    logic [H-1:0] hi, lo;
    case (op)
      3'd0: return l + r;
      3'd1: return l * r;
      3'd2: return (l > r) ? l : r;
      3'd3: return (l < r) ? l : r;
      3'd4: return l & r;
      3'd5: return l | r;
      3'd6: return l ^ r;
      default: begin
        hi = l[W-1:H] * r[W-1:H];
        lo = r[W-1:H] * l[H-1:0] + r[H-1:0];
        return {hi, lo};
      end
    endcase
  endfunction

  function automatic logic [N*W-1:0] ref_fold(input logic [2:0] op,
                                              input logic [N*W-1:0] v);
    logic [N*W-1:0] e;
    logic [W-1:0]   acc;
    acc = v[W-1:0];
    e[W-1:0] = acc;
    for (int k = 1; k < N; k++) begin
      acc = ref_op(op, acc, v[k*W +: W]);
      e[k*W +: W] = acc;
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] rand_vec();
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      v[k*W +: W] = seed[30:15];
    end
    return v;
  endfunction

  // Runs one scan; disturb pushes a second start, op and data mid-run (R7).
  task automatic run_scan(input string req, input logic [2:0] op,
                          input logic [N*W-1:0] v, input bit disturb);
    logic [N*W-1:0] exp;
    int late = 0;
    exp = ref_fold(op, v);
    @(negedge clk);
    start = 1'b1; op_sel = op; data_in = v;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= LG; k++) begin
      @(negedge clk);
      if (done !== (k == LG)) late++;
      if (disturb && k == 1) begin
        start = 1'b1; op_sel = op ^ 3'd5; data_in = ~v;
      end
      if (disturb && k == 2) start = 1'b0;
    end
    check({req, " R2 done timing"}, N*W'(late), '0);
    check({req, " R3 result"}, data_out, exp);
    @(negedge clk);
    check({req, " R2 done one cycle"}, N*W'(done), '0);
    last_exp = exp;
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; op_sel = '0; data_in = '1;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {busy, done, data_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after release", {busy, done, data_out}, '0);
  endtask

  task automatic t_each_op();
    for (int op = 0; op < 8; op++) begin
      run_scan(op < 3 ? "R4 op" : (op < 7 ? "R5 op" : "R6 affine"),
               3'(op), rand_vec(), 1'b0);
    end
  endtask

  task automatic t_corners();
    run_scan("R4 add wrap", 3'd0, {N{16'hFFFF}}, 1'b0);
    run_scan("R4 mul wrap", 3'd1, {N{16'h0101}}, 1'b0);
    run_scan("R4 max top", 3'd2, {16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000,
                                  16'h0000, 16'h1234, 16'h0002, 16'h0003}, 1'b0);
    run_scan("R5 min zero", 3'd3, {16'h0000, 16'h8000, 16'hFFFF, 16'h0007,
                                   16'h0009, 16'h7FFF, 16'h0100, 16'h00FF}, 1'b0);
    // Affine with distinct words: swapped operands give a different result.
    run_scan("R6 order", 3'd7, {16'h0302, 16'h0501, 16'h0203, 16'h0704,
                                16'h0305, 16'h0206, 16'h0907, 16'h0201}, 1'b0);
  endtask

  task automatic t_busy_ignore();
    run_scan("R7 restart ignored", 3'd0, rand_vec(), 1'b1);
    run_scan("R7 affine restart ignored", 3'd7, rand_vec(), 1'b1);
  endtask

  task automatic t_hold();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      data_in = rand_vec(); op_sel = 3'(k);
    end
    check("R8 idle hold", data_out, last_exp);
    check("R8 stays idle", N*W'({busy, done}), '0);
  endtask

  initial begin
    t_reset();
    t_each_op();
    t_corners();
    t_busy_ignore();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule